// File: doc/BRIEF.md
# Parallel-In Serial-Out FIFO with Status Flags

This block buffers 16-bit words that arrive on a parallel write port and hands them out one bit at a time on a single serial output line. Each pulse of the shift strobe moves one bit to the output. The storage holds 256 words, with separate write and read pointers. Everything runs in one synchronous clock domain. Writes and shifts are single-cycle enable strobes.

A word leaves the store on the first shift strobe that finds the output shifter idle and the FIFO not empty. That strobe also drives the word's first bit. The next 15 strobes drive the remaining bits. The order select input picks the bit order for each word and is captured when the word is loaded.

Four registered, active-low flags report the occupancy:
- empty
- full
- more than half full
- near either end (the edge flag)

A write into a full FIFO is dropped. A shift into an empty FIFO does nothing, and the output line keeps its last bit.

Top module: `piso_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `empty_n` and `edge_n` are 0, `full_n` and `half_n` are 1, and `ser_out` is 0.
- R2: Words come out in the order they were accepted. Each accepted word produces exactly 16 serial bits, one per shift strobe, and `ser_out` changes on the clock edge that takes the strobe.
- R3: A word loaded while `msb_first` is 0 is sent least significant bit first (bit 0, then bit 1, up to bit 15).
- R4: A word loaded while `msb_first` is 1 is sent most significant bit first (bit 15 down to bit 0).
- R5: A write while `full_n` is 0 stores nothing. The word is never sent, and the words already stored are unaffected.
- R6: A shift strobe while the shifter is idle and the FIFO is empty has no effect. `ser_out` holds the last bit sent, and the occupancy is unchanged.
- R7: `empty_n` is 0 exactly when the occupancy is 0.
- R8: `full_n` is 0 exactly when the occupancy is 256.
- R9: `half_n` is 0 exactly when the occupancy is 129 or more.
- R10: `edge_n` is 0 exactly when the occupancy is 0 to 31 or 225 to 256.
- R11: A write and a word load in the same cycle leave the occupancy unchanged. A word counts as removed from the occupancy in the cycle it is loaded into the shifter.
- R12: Changing `msb_first` while a word is being shifted does not change that word's bit order. All flags are registered and reflect the occupancy after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one word |
| wr_data | input | 16 | Parallel word to store |
| shift_en | input | 1 | Serial shift strobe, one bit per cycle |
| msb_first | input | 1 | Bit order select: 0 sends the LSB first, 1 sends the MSB first |
| ser_out | output | 1 | Serial data output |
| empty_n | output | 1 | Low when the FIFO is empty |
| full_n | output | 1 | Low when the FIFO is full |
| half_n | output | 1 | Low when the FIFO holds more than half its depth |
| edge_n | output | 1 | Low when the occupancy is below 1/8 or above 7/8 of the depth |

## Verification
The hardest situations to reach from the ports are those that need a specific occupancy while the shifter is in a specific phase. Examples are a write arriving in exactly the cycle a word is loaded at the half-full boundary, and a write attempted while the FIFO is exactly full.

The stimulus first fills the store one word at a time and checks each flag threshold on the way up. At an occupancy of 128 it starts a shift on an idle shifter together with a write, so the load and the write coincide. It then fills to 256 and offers an extra word that must never appear at the output.

The stimulus next drains the whole store. On the way it flips the order select in the middle of a word, and it keeps shifting after the store is empty. A behavioural queue model is compared with every output on every cycle throughout.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
    logic edge_n;
  } piso_flags_t;
endpackage

// File: rtl/piso_store.sv
module piso_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  output logic [WIDTH-1:0] rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (we) wr_ptr <= wr_ptr + AW'(1);
      if (re) rd_ptr <= rd_ptr + AW'(1);
    end
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/piso_level.sv
module piso_level
  import piso_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic        pop,
  output piso_flags_t flags
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [CW-1:0] HALFV = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LOWV  = CW'(DEPTH / 8);
  localparam logic [CW-1:0] HIGHV = CW'(DEPTH - DEPTH / 8);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  always_comb cnt_nxt = cnt + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      flags <= '{empty_n: 1'b0, full_n: 1'b1, half_n: 1'b1, edge_n: 1'b0};
    end else begin
      cnt           <= cnt_nxt;
      flags.empty_n <= (cnt_nxt != '0);
      flags.full_n  <= (cnt_nxt != FULLV);
      flags.half_n  <= !(cnt_nxt > HALFV);
      flags.edge_n  <= !((cnt_nxt < LOWV) || (cnt_nxt > HIGHV));
    end
  end

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULLV);

  // R11
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             avail,
  input  logic [WIDTH-1:0] word,
  input  logic             dir,
  output logic             take,
  output logic             ser_out
);
  localparam int IW = $clog2(WIDTH);
  localparam logic [IW-1:0] LAST = IW'(WIDTH - 1);

  logic             busy;
  logic             dir_q;
  logic [IW-1:0]    idx;
  logic [WIDTH-1:0] sreg;

  assign take = shift && !busy && avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      dir_q   <= 1'b0;
      idx     <= '0;
      sreg    <= '0;
      ser_out <= 1'b0;
    end else if (take) begin
      sreg    <= word;
      dir_q   <= dir;
      ser_out <= dir ? word[WIDTH-1] : word[0];
      idx     <= IW'(1);
      busy    <= 1'b1;
    end else if (shift && busy) begin
      ser_out <= dir_q ? sreg[LAST - idx] : sreg[idx];
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !busy && !avail) |=> $stable(ser_out));

  // R2
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(ser_out));

  // R12
  order_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !take) |=> (dir_q == $past(dir_q)));
endmodule

// File: rtl/piso_fifo.sv
module piso_fifo
  import piso_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             shift_en,
  input  logic             msb_first,
  output logic             ser_out,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             edge_n
);
  piso_flags_t      flags;
  logic             push;
  logic             take;
  logic [WIDTH-1:0] head;

  assign push = wr_en && flags.full_n;

  piso_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (push),
    .wdata (wr_data),
    .re    (take),
    .rdata (head)
  );

  piso_level #(.DEPTH(DEPTH)) u_level (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (take),
    .flags (flags)
  );

  piso_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift   (shift_en),
    .avail   (flags.empty_n),
    .word    (head),
    .dir     (msb_first),
    .take    (take),
    .ser_out (ser_out)
  );

  assign empty_n = flags.empty_n;
  assign full_n  = flags.full_n;
  assign half_n  = flags.half_n;
  assign edge_n  = flags.edge_n;

  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_n && wr_en && !shift_en) |=> !full_n);

  // R7
  empty_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !wr_en) |=> !empty_n);

  // R8
  full_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> (!half_n && !edge_n));

  // R10
  empty_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> (half_n && !edge_n && full_n));
endmodule

// File: tb/sim_piso_fifo.sv
module sim_piso_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        shift_en = 1'b0;
  logic        msb_first = 1'b0;
  logic        ser_out, empty_n, full_n, half_n, edge_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [15:0] q[$];
  logic [15:0] m_word;
  bit          m_busy = 0;
  bit          m_dir  = 0;
  int          m_idx  = 0;
  bit          m_so   = 0;

  always #4 clk = ~clk;

  piso_fifo u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .shift_en(shift_en), .msb_first(msb_first), .ser_out(ser_out),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n), .edge_n(edge_n)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, updated on every edge
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_busy = 0; m_idx = 0; m_so = 0; m_dir = 0;
    end else begin
      bit do_push;
      do_push = wr_en && (q.size() < 256);
      if (shift_en) begin
        if (m_busy) begin
          m_so = m_dir ? m_word[15 - m_idx] : m_word[m_idx];
          m_idx++;
          if (m_idx == 16) m_busy = 0;
        end else if (q.size() > 0) begin
          m_word = q.pop_front();
          m_dir  = msb_first;
          m_so   = m_dir ? m_word[15] : m_word[0];
          m_idx  = 1;
          m_busy = 1;
        end
      end
      if (do_push) q.push_back(wr_data);
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      int s;
      s = q.size();
      chk("R2 ser_out", ser_out, m_so);
      chk("R7 empty_n", empty_n, s != 0);
      chk("R8 full_n", full_n, s != 256);
      chk("R9 half_n", half_n, !(s >= 129));
      chk("R10 edge_n", edge_n, !(s <= 31 || s >= 225));
    end
  end

  task automatic cyc(bit we, logic [15:0] d, bit sh, bit dir);
    @(negedge clk);
    wr_en = we; wr_data = d; shift_en = sh; msb_first = dir;
  endtask

  task automatic idle();
    cyc(0, '0, 0, msb_first);
  endtask

  task automatic shift_word(bit dir, bit flip, output logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wr_en = 0; shift_en = 1;
      msb_first = (flip && i > 0) ? ~dir : dir;
      @(posedge clk); #2;
      w[dir ? 15 - i : i] = ser_out;
    end
    @(negedge clk);
    shift_en = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] w;
    logic        last;
    repeat (3) @(negedge clk);
    // R1: reset values while held and just after release
    chk("R1 empty_n", empty_n, 0); chk("R1 full_n", full_n, 1);
    chk("R1 half_n", half_n, 1);   chk("R1 edge_n", edge_n, 0);
    chk("R1 ser_out", ser_out, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 empty_n after", empty_n, 0);

    // R3 / R4 basic orders
    cyc(1, 16'h8421, 0, 0); cyc(1, 16'h00F1, 0, 0); idle();
    shift_word(0, 0, w); chk("R3 lsb-first word", w, 16'h8421);
    shift_word(1, 0, w); chk("R4 msb-first word", w, 16'h00F1);

    // R6: shifts on an empty FIFO keep the last bit
    last = ser_out;
    repeat (3) cyc(0, '0, 1, 0);
    idle();
    chk("R6 ser_out hold", ser_out, last);
    chk("R6 still empty", empty_n, 0);

    // R12: order flipped mid-word has no effect
    cyc(1, 16'hA5C3, 0, 0); idle();
    shift_word(1, 1, w); chk("R12 order latched", w, 16'hA5C3);

    // fill while checking thresholds (R7..R10)
    for (int i = 1; i <= 128; i++) begin
      cyc(1, 16'(i * 16'h3B1 + 7), 0, 0);
      if (i == 1)  begin idle(); chk("R7 not empty at 1", empty_n, 1); end
      if (i == 31) begin idle(); chk("R10 edge at 31", edge_n, 0); end
      if (i == 32) begin idle(); chk("R10 clear at 32", edge_n, 1); end
    end
    idle();
    chk("R9 half clear at 128", half_n, 1);
    // R11: write and load together at 128 keep the count
    cyc(1, 16'h1234, 1, 1);
    idle();
    chk("R11 half at 128 after write+load", half_n, 1);
    for (int b = 1; b < 16; b++) cyc(0, '0, 1, 1);
    idle();
    cyc(1, 16'h4321, 0, 0); idle();
    chk("R9 half at 129", half_n, 0);
    for (int i = 130; i <= 256; i++) begin
      cyc(1, 16'(i * 16'h1F5), 0, 0);
      if (i == 224) begin idle(); chk("R10 clear at 224", edge_n, 1); end
      if (i == 225) begin idle(); chk("R10 edge at 225", edge_n, 0); end
      if (i == 255) begin idle(); chk("R8 not full at 255", full_n, 1); end
    end
    idle();
    chk("R8 full at 256", full_n, 0);
    // R5: extra write must be dropped
    cyc(1, 16'hDEAD, 0, 0); idle();
    chk("R5 still full", full_n, 0);

    // drain everything, alternating order; model checks each bit (R2, R5)
    for (int k = 0; k < 256; k++) shift_word(k[0], k % 5 == 0, w);
    idle();
    chk("R7 empty after drain", empty_n, 0);
    last = ser_out;
    repeat (4) cyc(0, '0, 1, 1);
    idle();
    chk("R6 hold after drain", ser_out, last);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule